// File: doc/BRIEF.md
# UART Register and Interrupt Front-End

This block is the software-visible face of a 16550-style serial port. It has no bit timing and no shift register. It holds the state a driver sees: a one-character receive holding register, a one-character transmit holding register, sticky line errors, modem line levels with change flags, and the configuration words that the serialiser next to it consumes. A prioritised interrupt is evaluated from that state, and its identification code and a level interrupt are produced from it.

The CPU side is a simple word-indexed register port with one transfer per cycle. Reads return data in the same cycle, and read side effects take place at the clock edge that ends the transfer. Received bytes enter on a valid/ready stream. `rx_ready` is low while a byte is held. A byte is taken on any edge where `rx_valid` and `rx_ready` are both high. Bytes written for transmission leave on a valid/ready stream. `tx_valid` stays high and `tx_data` stays fixed until the edge where `tx_ready` is high. The serialiser may hold `tx_ready` low for as long as it needs.

The parameter `OVERWRITE_FULL` selects a receive variant in which `rx_ready` is always high. In that variant a new byte replaces a byte that has not been read, and the loss is flagged as an overrun.

Top module: `uart_regfront`

## Requirements
- R1: The register index is `bus_addr`. 0 is data, 1 is interrupt enable, 2 is ident, 3 is line control, 4 is modem control, 5 is line status, 6 is modem status and 7 is divisor. Indices 1, 3, 4 and 7 read as zero. Indices 8 and above read as zero and writes to them change nothing.
- R2: A write to index 1 stores bits 3:0 as the interrupt enables. A write to index 3 stores bits 7:0 on `line_ctrl`. A write to index 4 stores bits 7:0 on `modem_ctrl`. A write to index 7 stores the word on `divisor`. Writes to indices 2, 5 and 6 are ignored.
- R3: After reset, line status reads 0x60 and ident reads 0x01. `irq`, `tx_valid` and the configuration outputs are zero, and `rx_ready` is high.
- R4: Line status bit 0 (data ready) is set when a byte is accepted. With `OVERWRITE_FULL`=0, `rx_ready` is the inverse of data ready.
- R5: Reading index 0 returns the held byte in bits 7:0. Data ready is clear after the edge that ends the read.
- R6: With `OVERWRITE_FULL`=1, `rx_ready` stays high. A byte accepted while data ready is set, with no data read in the same cycle, replaces the held byte and sets line status bit 1 (overrun). Data ready stays set.
- R7: Pulses on `err_parity`, `err_frame` and `err_break` set line status bits 2, 3 and 4. These bits and bit 1 stay set until a line status read clears them. A set in the same cycle as the read takes precedence over the clear.
- R8: A write to index 0 while `tx_valid` is low loads bits 7:0 and raises `tx_valid`. `tx_data` holds until the `tx_ready` handshake. A write to index 0 while `tx_valid` is high is dropped. Line status bits 5 and 6 are set exactly when `tx_valid` is low.
- R9: Modem status bits 7:4 show `modem_lines[3:0]`. Bits 3:0 are set on any change of the matching line and are cleared by a modem status read.
- R10: Ident is computed in this order, highest first. Any of line status bits 1–4 with enable bit 2 gives 0b110. Otherwise data ready with enable bit 0 gives 0b100. Otherwise transmit empty with enable bit 1 gives 0b010. Otherwise any modem change flag with enable bit 3 gives 0b000. Otherwise ident is 0b001.
- R11: `irq` is high exactly when ident bit 0 is low, and it follows the current state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register transfer this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the transfer |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Block can take a byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Serialiser takes the byte |
| err_parity | input | 1 | Parity error pulse |
| err_frame | input | 1 | Framing error pulse |
| err_break | input | 1 | Break pulse |
| modem_lines | input | 4 | Line levels: bit0 CTS, bit1 DSR, bit2 RI, bit3 DCD |
| line_ctrl | output | 8 | Stored line control |
| modem_ctrl | output | 8 | Stored modem control |
| divisor | output | 32 | Stored divisor |
| irq | output | 1 | Level interrupt |

## Verification
The checker covers the cycle-level relations on every cycle. It checks that a handshake on either stream has the required effect one edge later, that a data read empties the holder, that an overrun is flagged, that the line-error class takes priority in the ident code, and that `irq` and ident agree. The following can only be shown by bench scenarios: the exact register read values, the zero reads of write-only and unmapped indices, the dropping of a write into a full transmit holder, the modem change flags, and each step down the priority order. A second instance built with the overwrite variant receives the same stimulus, so the overrun path is exercised next to the back-pressured one.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int REG_COUNT = 8;
  localparam int BYTE_W    = 8;
  localparam int MODEM_N   = 4;
  localparam int ERR_N     = 4;

  // register indices (order is decoded by software)
  localparam logic [2:0] IX_DATA  = 3'd0;
  localparam logic [2:0] IX_IEN   = 3'd1;
  localparam logic [2:0] IX_IDENT = 3'd2;
  localparam logic [2:0] IX_LCTL  = 3'd3;
  localparam logic [2:0] IX_MCTL  = 3'd4;
  localparam logic [2:0] IX_LSTAT = 3'd5;
  localparam logic [2:0] IX_MSTAT = 3'd6;
  localparam logic [2:0] IX_DIV   = 3'd7;

  // interrupt enable bit positions
  localparam int EN_RXD  = 0;
  localparam int EN_THRE = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  typedef enum logic [2:0] {
    ID_MODEM = 3'b000,
    ID_NONE  = 3'b001,
    ID_THRE  = 3'b010,
    ID_RXD   = 3'b100,
    ID_LINE  = 3'b110
  } irq_id_e;
endpackage

// File: rtl/uart_rf_rxhold.sv
module uart_rf_rxhold #(
  parameter int DATA_W         = 8,
  parameter bit OVERWRITE_FULL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic [DATA_W-1:0] held,
  output logic              avail,
  output logic              lost
);
  logic accept;

  generate
    if (OVERWRITE_FULL) begin : g_always_ready
      assign in_ready = 1'b1;
    end else begin : g_backpressure
      assign in_ready = ~avail;
    end
  endgenerate

  assign accept = in_valid & in_ready;
  assign lost   = accept & avail & ~take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= '0;
      avail <= 1'b0;
    end else if (accept) begin
      held  <= in_data;
      avail <= 1'b1;
    end else if (take) begin
      avail <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rf_txhold.sv
module uart_rf_txhold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (out_valid) begin
      if (out_ready) out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end
  end
endmodule

// File: rtl/uart_rf_status.sv
module uart_rf_status #(
  parameter int ERR_N   = 4,
  parameter int MODEM_N = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ERR_N-1:0]   err_set,
  input  logic               err_clr,
  output logic [ERR_N-1:0]   err_q,
  input  logic [MODEM_N-1:0] lines,
  input  logic               delta_clr,
  output logic [MODEM_N-1:0] level_q,
  output logic [MODEM_N-1:0] delta_q
);
  generate
    for (genvar e = 0; e < ERR_N; e++) begin : g_err
      always_ff @(posedge clk) begin
        if (!rst_n)          err_q[e] <= 1'b0;
        else if (err_set[e]) err_q[e] <= 1'b1;
        else if (err_clr)    err_q[e] <= 1'b0;
      end
    end

    for (genvar m = 0; m < MODEM_N; m++) begin : g_mdm
      logic change;
      assign change = lines[m] ^ level_q[m];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          level_q[m] <= 1'b0;
          delta_q[m] <= 1'b0;
        end else begin
          level_q[m] <= lines[m];
          if (change)         delta_q[m] <= 1'b1;
          else if (delta_clr) delta_q[m] <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
#(
  parameter int ERR_N   = 4,
  parameter int MODEM_N = 4
) (
  input  logic [3:0]         enables,
  input  logic [ERR_N-1:0]   errors,
  input  logic               data_ready,
  input  logic               tx_empty,
  input  logic [MODEM_N-1:0] modem_delta,
  output irq_id_e            ident,
  output logic               irq
);
  logic line_p, rxd_p, thre_p, mdm_p;

  assign line_p = (|errors)      & enables[EN_LINE];
  assign rxd_p  = data_ready     & enables[EN_RXD];
  assign thre_p = tx_empty       & enables[EN_THRE];
  assign mdm_p  = (|modem_delta) & enables[EN_MDM];

  assign irq = line_p | rxd_p | thre_p | mdm_p;

  always_comb begin
    if (line_p)      ident = ID_LINE;
    else if (rxd_p)  ident = ID_RXD;
    else if (thre_p) ident = ID_THRE;
    else if (mdm_p)  ident = ID_MODEM;
    else             ident = ID_NONE;
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W         = 4,
  parameter int BUS_W          = 32,
  parameter int DIV_W          = 32,
  parameter bit OVERWRITE_FULL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              err_parity,
  input  logic              err_frame,
  input  logic              err_break,
  input  logic [3:0]        modem_lines,
  output logic [7:0]        line_ctrl,
  output logic [7:0]        modem_ctrl,
  output logic [DIV_W-1:0]  divisor,
  output logic              irq
);
  localparam int IX_W = $clog2(REG_COUNT);

  logic              mapped;
  logic [IX_W-1:0]   idx;
  logic              wr_en, rd_en;
  logic [REG_COUNT-1:0] wr_hit, rd_hit;

  assign mapped = (bus_addr < ADDR_W'(REG_COUNT));
  assign idx    = bus_addr[IX_W-1:0];
  assign wr_en  = bus_sel &  bus_we & mapped;
  assign rd_en  = bus_sel & ~bus_we & mapped;

  generate
    for (genvar r = 0; r < REG_COUNT; r++) begin : g_hit
      assign wr_hit[r] = wr_en & (idx == IX_W'(r));
      assign rd_hit[r] = rd_en & (idx == IX_W'(r));
    end
  endgenerate

  // write-only configuration storage
  logic [3:0] ien_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q      <= '0;
      line_ctrl  <= '0;
      modem_ctrl <= '0;
      divisor    <= '0;
    end else begin
      if (wr_hit[IX_IEN])  ien_q      <= bus_wdata[3:0];
      if (wr_hit[IX_LCTL]) line_ctrl  <= bus_wdata[7:0];
      if (wr_hit[IX_MCTL]) modem_ctrl <= bus_wdata[7:0];
      if (wr_hit[IX_DIV])  divisor    <= bus_wdata[DIV_W-1:0];
    end
  end

  // receive holder
  logic [BYTE_W-1:0] rx_held;
  logic              rx_avail, rx_lost, rd_take;
  assign rd_take = rd_hit[IX_DATA];

  uart_rf_rxhold #(.DATA_W(BYTE_W), .OVERWRITE_FULL(OVERWRITE_FULL)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_data(rx_data), .in_ready(rx_ready),
    .take(rd_take), .held(rx_held), .avail(rx_avail), .lost(rx_lost)
  );

  // transmit holder
  uart_rf_txhold #(.DATA_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load(wr_hit[IX_DATA]), .load_data(bus_wdata[BYTE_W-1:0]),
    .out_valid(tx_valid), .out_data(tx_data), .out_ready(tx_ready)
  );

  // sticky errors and modem status
  logic [ERR_N-1:0]   err_q;
  logic [MODEM_N-1:0] mdm_level, mdm_delta;

  uart_rf_status #(.ERR_N(ERR_N), .MODEM_N(MODEM_N)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .err_set({err_break, err_frame, err_parity, rx_lost}),
    .err_clr(rd_hit[IX_LSTAT]), .err_q(err_q),
    .lines(modem_lines), .delta_clr(rd_hit[IX_MSTAT]),
    .level_q(mdm_level), .delta_q(mdm_delta)
  );

  logic       tx_empty;
  logic [7:0] lstat, mstat;
  assign tx_empty = ~tx_valid;
  assign lstat    = {1'b0, tx_empty, tx_empty, err_q, rx_avail};
  assign mstat    = {mdm_level, mdm_delta};

  // interrupt evaluation
  irq_id_e ident;
  uart_rf_irq #(.ERR_N(ERR_N), .MODEM_N(MODEM_N)) u_irq (
    .enables(ien_q), .errors(err_q), .data_ready(rx_avail),
    .tx_empty(tx_empty), .modem_delta(mdm_delta),
    .ident(ident), .irq(irq)
  );

  // read mux: write-only and unmapped indices return zero
  always_comb begin
    bus_rdata = '0;
    if (mapped) begin
      unique case (idx)
        IX_DATA:  bus_rdata[BYTE_W-1:0] = rx_held;
        IX_IDENT: bus_rdata[2:0]        = ident;
        IX_LSTAT: bus_rdata[7:0]        = lstat;
        IX_MSTAT: bus_rdata[7:0]        = mstat;
        default:  bus_rdata             = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_rf_chk.sv
module uart_rf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       irq,
  input logic [2:0] ident,
  input logic [7:0] lstat,
  input logic [3:0] ien,
  input logic       rd_take
);
  // R4: back-pressure only while a byte is held
  p_low_ready_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> lstat[0]);

  // R4: accepted byte marks data ready
  p_accept_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> lstat[0]);

  // R5: data read empties the holder unless a byte lands the same cycle
  p_read_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !(rx_valid && rx_ready)) |=> !lstat[0]);

  // R6: byte into a full holder flags overrun
  p_lost_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && lstat[0] && !rd_take) |=> lstat[1]);

  // R8: outgoing byte holds under back-pressure
  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R8: handshake empties the transmit holder
  p_tx_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> lstat[5]);

  // R10: line errors win
  p_line_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|lstat[4:1]) && ien[2]) |-> (ident == 3'b110));

  // R11: level output agrees with ident
  p_irq_ident_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !ident[0]);
endmodule

bind uart_regfront uart_rf_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .irq(irq), .ident(ident), .lstat(lstat), .ien(ien_q), .rd_take(rd_take)
);

// File: tb/sim_uart_regfront.sv
`timescale 1ns/1ps
module sim_uart_regfront;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready0, rx_ready1;
  logic        tx_valid0, tx_valid1;
  logic [7:0]  tx_data0, tx_data1;
  logic        tx_rdy = 1'b0;
  logic        err_parity = 1'b0, err_frame = 1'b0, err_break = 1'b0;
  logic [3:0]  modem_lines = '0;
  logic [7:0]  lctl0, mctl0, lctl1, mctl1;
  logic [31:0] div0, div1;
  logic        irq0, irq1;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  tx_q[$];

  always #4 clk = ~clk;

  uart_regfront u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready0),
    .tx_valid(tx_valid0), .tx_data(tx_data0), .tx_ready(tx_rdy),
    .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break),
    .modem_lines(modem_lines), .line_ctrl(lctl0), .modem_ctrl(mctl0),
    .divisor(div0), .irq(irq0));

  uart_regfront #(.OVERWRITE_FULL(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready1),
    .tx_valid(tx_valid1), .tx_data(tx_data1), .tx_ready(tx_rdy),
    .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break),
    .modem_lines(modem_lines), .line_ctrl(lctl1), .modem_ctrl(mctl1),
    .divisor(div1), .irq(irq1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares reads and transmit handshakes against the scoreboard
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_we) begin
      if (exp_q.size() == 0) chk("R1 unexpected read", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), rdata0, exp_q.pop_front());
    end
    if (rst_n && tx_valid0 && tx_rdy) begin
      if (tx_q.size() == 0) chk("R8 unexpected tx byte", {24'h0, tx_data0}, 32'h0);
      else chk("R8 tx byte", {24'h0, tx_data0}, {24'h0, tx_q.pop_front()});
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e0, input bit use1,
                    input logic [31:0] e1, input string tag);
    exp_q.push_back(e0); tag_q.push_back(tag);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    if (use1) chk({tag, " (overwrite variant)"}, rdata1, e1);
    cyc();
    bus_sel = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    cyc();
    rx_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R3 reset state
    chk("R3 irq", {31'h0, irq0}, 32'h0);
    chk("R3 rx_ready", {31'h0, rx_ready0}, 32'h1);
    chk("R3 tx_valid", {31'h0, tx_valid0}, 32'h0);
    chk("R3 config", {lctl0, mctl0, div0[15:0]}, 32'h0);
    rd(4'd5, 32'h60, 0, 0, "R3 line status");
    rd(4'd2, 32'h01, 0, 0, "R3 ident");

    // R2 storage, R1 zero reads
    wr(4'd1, 32'hFFFF_FFF0);
    wr(4'd3, 32'h0000_01A5);
    wr(4'd4, 32'h0000_003C);
    wr(4'd7, 32'h0012_3456);
    chk("R2 line_ctrl", {24'h0, lctl0}, 32'hA5);
    chk("R2 modem_ctrl", {24'h0, mctl0}, 32'h3C);
    chk("R2 divisor", div0, 32'h0012_3456);
    rd(4'd1, 32'h0, 0, 0, "R1 enable reads zero");
    rd(4'd3, 32'h0, 0, 0, "R1 line ctrl reads zero");
    rd(4'd4, 32'h0, 0, 0, "R1 modem ctrl reads zero");
    rd(4'd7, 32'h0, 0, 0, "R1 divisor reads zero");
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd5, 32'hFF);
    wr(4'd6, 32'hFF);
    wr(4'd2, 32'hFF);
    rd(4'd9, 32'h0, 0, 0, "R1 unmapped reads zero");
    rd(4'd15, 32'h0, 0, 0, "R1 unmapped top reads zero");
    rd(4'd5, 32'h60, 0, 0, "R2 line status unwritable");
    rd(4'd6, 32'h00, 0, 0, "R2 modem status unwritable");
    rd(4'd2, 32'h01, 0, 0, "R2 ident unwritable");
    chk("R1 unmapped write no effect", {lctl0, mctl0, div0[15:0]}, 32'hA53C3456);

    // R4 R5 R6 receive path
    rx_push(8'h5A);
    chk("R4 rx_ready low when held", {31'h0, rx_ready0}, 32'h0);
    chk("R6 rx_ready stays high", {31'h0, rx_ready1}, 32'h1);
    rd(4'd5, 32'h61, 1, 32'h61, "R4 data ready set");
    rx_push(8'hC3);
    rd(4'd5, 32'h61, 1, 32'h63, "R6 overrun flagged");
    rd(4'd0, 32'h5A, 1, 32'hC3, "R5 held byte");
    rd(4'd5, 32'h60, 1, 32'h60, "R5 data ready cleared");
    chk("R4 rx_ready back high", {31'h0, rx_ready0}, 32'h1);

    // R7 sticky errors
    err_parity = 1'b1; cyc(); err_parity = 1'b0;
    err_frame  = 1'b1; cyc(); err_frame  = 1'b0;
    err_break  = 1'b1; cyc(); err_break  = 1'b0;
    cyc();
    rd(4'd5, 32'h7C, 0, 0, "R7 errors sticky");
    rd(4'd5, 32'h60, 0, 0, "R7 errors cleared by read");

    // R8 transmit path
    tx_q.push_back(8'hA7);
    wr(4'd0, 32'h0000_01A7);
    chk("R8 tx_valid raised", {31'h0, tx_valid0}, 32'h1);
    rd(4'd5, 32'h00, 0, 0, "R8 empty bits low");
    wr(4'd0, 32'h55);
    cyc(); cyc();
    chk("R8 write into full dropped", {24'h0, tx_data0}, 32'hA7);
    tx_rdy = 1'b1; cyc(); tx_rdy = 1'b0;
    chk("R8 tx_valid after handshake", {31'h0, tx_valid0}, 32'h0);
    rd(4'd5, 32'h60, 0, 0, "R8 empty bits set");
    tx_rdy = 1'b1;
    tx_q.push_back(8'h3C);
    wr(4'd0, 32'h3C);
    cyc();
    chk("R8 streaming drain", {31'h0, tx_valid0}, 32'h0);
    tx_rdy = 1'b0;

    // R9 modem status
    modem_lines = 4'b0101; cyc();
    rd(4'd6, 32'h55, 1, 32'h55, "R9 levels and changes");
    rd(4'd6, 32'h50, 1, 32'h50, "R9 changes cleared");

    // R10 R11 priority
    wr(4'd1, 32'h2);
    chk("R11 irq with empty enable", {31'h0, irq0}, 32'h1);
    rd(4'd2, 32'h02, 0, 0, "R10 transmit empty ident");
    wr(4'd1, 32'hF);
    rd(4'd2, 32'h02, 0, 0, "R10 all enabled idle");
    rx_push(8'h11);
    rd(4'd2, 32'h04, 0, 0, "R10 rx over transmit");
    err_break = 1'b1; cyc(); err_break = 1'b0;
    rd(4'd2, 32'h06, 0, 0, "R10 line over rx");
    rd(4'd5, 32'h71, 0, 0, "R7 break with data");
    rd(4'd2, 32'h04, 0, 0, "R10 back to rx");
    rd(4'd0, 32'h11, 0, 0, "R5 second byte");
    rd(4'd2, 32'h02, 0, 0, "R10 back to transmit");
    tx_q.push_back(8'h99);
    wr(4'd0, 32'h99);
    rd(4'd2, 32'h01, 0, 0, "R10 none pending");
    chk("R11 irq low", {31'h0, irq0}, 32'h0);
    modem_lines = 4'b0100; cyc();
    chk("R11 irq on modem change", {31'h0, irq0}, 32'h1);
    rd(4'd2, 32'h00, 0, 0, "R10 modem ident");
    rd(4'd6, 32'h41, 0, 0, "R9 falling change");
    rd(4'd2, 32'h01, 0, 0, "R10 modem cleared");
    wr(4'd1, 32'h0);
    tx_rdy = 1'b1; cyc(); tx_rdy = 1'b0;
    cyc();

    chk("R8 all tx bytes seen", tx_q.size(), 32'h0);
    chk("R1 all reads compared", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule